// File: doc/BRIEF.md
# Triggered Pattern RAM Sequencer

The block plays a window of a small pattern memory onto 24 output lines. Each stored word holds one bit for each line. The window is set by a start and an end byte address, both word aligned. The sequencer steps upward through the window one word at a time. Each word stays on the outputs for a programmed number of 10 µs ticks, and the tick length is a parameter given in clock cycles.

A five-bit control word selects how the window is played:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | burst (a fixed number of passes instead of endless looping) |
| 2 | pause |
| 3 | start on a rising edge of the trigger input |
| 4 | start on a falling edge of the trigger input |

The trigger input is the channel-1 line, which must then be used as an input. A host loads the memory through a simple write port. It then sets the window, the period, the pass count and the control word, and watches the busy flag.

Top module: `pattern_sequencer`

## Requirements
- R1: Pattern words are stored at word index `wr_addr[AW-1:2]`. Output line n (`pat_out[n]`) carries bit n of the word played. Bits 31..24 of a written word never reach the outputs.
- R2: With enable set and no trigger bit set, the word at `start_addr` appears on `pat_out` on the clock edge after the control word is sampled, and `busy` rises. Words follow in ascending order, 4 bytes apart, up to and including `end_addr`. Each word is held for `period * TICK_DIV` clock cycles.
- R3: A `period` of 0 is treated as 1.
- R4: In continuous mode (burst bit 0), the word at `end_addr` is followed by the word at `start_addr`, with no end to the looping.
- R5: In burst mode, the window is played `cycles` times, and a count of 0 plays it once. Afterwards, without a trigger bit, `pat_out` holds the last word and `busy` stays low until enable is cleared and set again.
- R6: While pause (bit 2) is set during a run, `pat_out` and the position stay frozen and `busy` stays high. After pause is cleared, the next word appears a full `period * TICK_DIV` cycles later.
- R7: Some control values are invalid: pause without enable, both trigger bits set, or `start_addr >= end_addr`. An invalid value leaves the sequencer idle, with `busy` low and `pat_out` unchanged.
- R8: With bit 3 or bit 4 set, the sequencer waits armed, with `busy` low and the outputs unchanged, until a rising (bit 3) or falling (bit 4) edge on `trig_in`. The edge of the other direction is ignored. After the edge, a continuous run loops, and a burst plays its passes and then returns to armed for the next edge.
- R9: Clearing enable stops the sequencer. `busy` is low after the next edge, and `pat_out` keeps its value.
- R10: After reset, `pat_out` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | AW | Byte address of the word written |
| wr_data | input | 32 | Pattern word; low CH bits are stored |
| start_addr | input | AW | Byte address of the first word of the window |
| end_addr | input | AW | Byte address of the last word of the window |
| period | input | 32 | Ticks each word is held |
| ctrl | input | 5 | Enable, burst, pause, rising trigger, falling trigger |
| cycles | input | 32 | Number of passes in burst mode |
| trig_in | input | 1 | Channel-1 input used as the start trigger |
| pat_out | output | CH | Per-channel output levels |
| busy | output | 1 | High while the window is being played |

## Verification
The assertions rely on four conditions about the inputs:
- The window and the period stay constant while the sequencer is running.
- The memory is written only while it is idle.
- `trig_in` is already synchronous to `clk`.
- A paused run keeps enable set.

The stimulus meets these conditions by changing the window, period and pass count only while enable is clear. It writes the memory once before the first run and drives every input at falling clock edges. Each played window has distinct consecutive words, so every step shows up as a change on `pat_out`.

// File: rtl/pattern_sequencer.sv
module pattern_sequencer #(
  parameter int CH       = 24,
  parameter int DEPTH    = 256,
  parameter int TICK_DIV = 2000,
  localparam int IW = $clog2(DEPTH),
  localparam int AW = IW + 2,
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  input  logic [31:0]   period,
  input  logic [4:0]    ctrl,
  input  logic [31:0]   cycles,
  input  logic          trig_in,
  output logic [CH-1:0] pat_out,
  output logic          busy
);
  typedef enum logic [1:0] {IDLE, ARMED, RUN, DONE} st_t;

  logic [CH-1:0] mem [DEPTH];
  st_t           st;
  logic [IW-1:0] idx;
  logic [TW-1:0] pre;
  logic [31:0]   tk, pass;
  logic          trig_q;

  wire en    = ctrl[0];
  wire burst = ctrl[1];
  wire pause = ctrl[2];
  wire rise  = ctrl[3];
  wire fall  = ctrl[4];

  wire [IW-1:0] s_idx = start_addr[AW-1:2];
  wire [IW-1:0] e_idx = end_addr[AW-1:2];
  wire valid     = !(pause && !en) && !(rise && fall) && (s_idx < e_idx);
  wire go        = en && valid;
  wire trig_mode = rise || fall;
  wire hit       = (rise && trig_in && !trig_q) || (fall && !trig_in && trig_q);

  wire [31:0] per_last  = (period == 32'd0) ? 32'd0 : period - 32'd1;
  wire [31:0] pass_last = (cycles == 32'd0) ? 32'd0 : cycles - 32'd1;
  wire tick_end = (pre == TW'(TICK_DIV - 1));
  wire step     = tick_end && (tk == per_last);
  wire at_end   = (idx == e_idx);
  wire fin      = burst && (pass == pass_last);

  wire unused_ok = &{1'b0, wr_data[31:CH], wr_addr[1:0], start_addr[1:0], end_addr[1:0]};

  assign busy = (st == RUN);

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr[AW-1:2]] <= wr_data[CH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      idx     <= '0;
      pre     <= '0;
      tk      <= '0;
      pass    <= '0;
      trig_q  <= 1'b0;
      pat_out <= '0;
    end else begin
      trig_q <= trig_in;
      if (!go) begin
        st <= IDLE;
      end else begin
        case (st)
          IDLE: begin
            if (trig_mode) st <= ARMED;
            else begin
              st <= RUN; idx <= s_idx; pat_out <= mem[s_idx];
              pre <= '0; tk <= '0; pass <= '0;
            end
          end
          ARMED: begin
            if (hit) begin
              st <= RUN; idx <= s_idx; pat_out <= mem[s_idx];
              pre <= '0; tk <= '0; pass <= '0;
            end
          end
          RUN: begin
            if (pause) begin
              pre <= '0; tk <= '0;
            end else if (step) begin
              pre <= '0; tk <= '0;
              if (at_end) begin
                if (fin) st <= trig_mode ? ARMED : DONE;
                else begin
                  pass <= pass + 32'd1; idx <= s_idx; pat_out <= mem[s_idx];
                end
              end else begin
                idx <= idx + 1'b1; pat_out <= mem[idx + 1'b1];
              end
            end else if (tick_end) begin
              pre <= '0; tk <= tk + 32'd1;
            end else begin
              pre <= pre + 1'b1;
            end
          end
          default: st <= DONE;
        endcase
      end
    end
  end

  a_r7_invalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !busy);
  a_r9_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> (!busy && $stable(pat_out)));
  a_r6_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN && go && pause) |=> ($stable(pat_out) && busy));
  a_r8_armed_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARMED && go && !hit) |=> (!busy && $stable(pat_out)));
  a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DONE && go) |=> (!busy && $stable(pat_out)));
  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx >= s_idx && idx <= e_idx));
endmodule

// File: tb/tb_pattern_sequencer.sv
module tb_pattern_sequencer;
  localparam int TD = 4;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic [31:0]   period = '0;
  logic [4:0]    ctrl = '0;
  logic [31:0]   cycles = '0;
  logic          trig_in = 1'b0;
  logic [23:0]   pat_out;
  logic          busy;

  pattern_sequencer #(.TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_addr(start_addr), .end_addr(end_addr), .period(period), .ctrl(ctrl),
    .cycles(cycles), .trig_in(trig_in), .pat_out(pat_out), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [23:0] qw[$];
  int          qh[$];
  string       qt[$];
  logic [23:0] last = '0;
  int          since = 0;

  function automatic logic [31:0] raw(input int i);
    return {8'hA5, 24'(i * 24'h111111 + 24'h0F0F01)};
  endfunction

  function automatic logic [23:0] wd(input int i);
    logic [31:0] r;
    r = raw(i);
    return r[23:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int i, input int hold, input string tag);
    qw.push_back(wd(i));
    qh.push_back(hold);
    qt.push_back(tag);
  endtask

  task automatic drain();
    while (qw.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    since++;
    if (pat_out !== last) begin
      if (qw.size() == 0) begin
        chk(1'b0, "R7", "unexpected output change", 32'(pat_out), 32'(last));
      end else begin
        logic [23:0] w;
        int h;
        string t;
        w = qw.pop_front();
        h = qh.pop_front();
        t = qt.pop_front();
        chk(pat_out == w, t, "word played", 32'(pat_out), 32'(w));
        if (h != 0) chk(since == h, "R2", "hold length", since, h);
      end
      last = pat_out;
      since = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pat_out == 24'h0, "R10", "pat_out after reset", 32'(pat_out), 0);
    chk(busy == 1'b0, "R10", "busy after reset", 32'(busy), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(i * 4); wr_data = raw(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
    start_addr = AW'(16); end_addr = AW'(24);

    // burst of two passes, period 2
    period = 2; cycles = 2;
    push(4, 0, "R1"); push(5, 2*TD, "R2"); push(6, 2*TD, "R2");
    push(4, 2*TD, "R5"); push(5, 2*TD, "R5"); push(6, 2*TD, "R5");
    ctrl = 5'b00011;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
    chk(pat_out == wd(4), "R2", "first word next cycle", 32'(pat_out), 32'(wd(4)));
    drain();
    repeat (4*TD) @(negedge clk);
    chk(busy == 1'b0, "R5", "busy after burst", 32'(busy), 0);
    chk(pat_out == wd(6), "R5", "last word held", 32'(pat_out), 32'(wd(6)));
    ctrl = 5'b0;
    repeat (3) @(negedge clk);

    // period 0 and cycle count 0
    period = 0; cycles = 0;
    push(4, 0, "R3"); push(5, TD, "R3"); push(6, TD, "R3");
    ctrl = 5'b00011;
    drain();
    repeat (4*TD) @(negedge clk);
    chk(busy == 1'b0, "R5", "single pass for count 0", 32'(busy), 0);
    ctrl = 5'b0;
    repeat (3) @(negedge clk);

    // invalid control values
    period = 1;
    ctrl = 5'b00100;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R7", "pause without enable", 32'(busy), 0);
    ctrl = 5'b11001;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R7", "both trigger edges", 32'(busy), 0);
    ctrl = 5'b0;
    start_addr = AW'(24); end_addr = AW'(16);
    @(negedge clk);
    ctrl = 5'b00001;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R7", "start not below end", 32'(busy), 0);
    chk(pat_out == wd(6), "R7", "output unchanged", 32'(pat_out), 32'(wd(6)));
    ctrl = 5'b0;
    @(negedge clk);
    start_addr = AW'(16); end_addr = AW'(24);
    @(negedge clk);

    // continuous with wrap, then pause
    push(4, 0, "R2"); push(5, TD, "R2"); push(6, TD, "R2"); push(4, TD, "R4");
    ctrl = 5'b00001;
    drain();
    ctrl = 5'b00101;
    repeat (20) @(negedge clk);
    chk(pat_out == wd(4), "R6", "word frozen in pause", 32'(pat_out), 32'(wd(4)));
    chk(busy == 1'b1, "R6", "busy in pause", 32'(busy), 1);
    push(5, 0, "R6");
    ctrl = 5'b00001;
    repeat (TD-1) @(negedge clk);
    chk(pat_out == wd(4), "R6", "fresh period after resume", 32'(pat_out), 32'(wd(4)));
    @(negedge clk);
    chk(pat_out == wd(5), "R6", "advance after resume", 32'(pat_out), 32'(wd(5)));
    ctrl = 5'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after disable", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(pat_out == wd(5), "R9", "output held after disable", 32'(pat_out), 32'(wd(5)));

    // rising trigger, burst of one pass
    cycles = 1;
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
    ctrl = 5'b01011;
    repeat (10) @(negedge clk);
    trig_in = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R8", "armed ignores other edge", 32'(busy), 0);
    chk(pat_out == wd(5), "R8", "armed output unchanged", 32'(pat_out), 32'(wd(5)));
    for (int k = 0; k < 2; k++) begin
      push(4, 0, "R8"); push(5, TD, "R8"); push(6, TD, "R8");
      trig_in = 1'b1;
      drain();
      repeat (2*TD) @(negedge clk);
      chk(busy == 1'b0, "R8", "burst back to armed", 32'(busy), 0);
      trig_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    ctrl = 5'b0;
    trig_in = 1'b1;
    repeat (3) @(negedge clk);

    // falling trigger, continuous
    ctrl = 5'b10001;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R8", "waiting for falling edge", 32'(busy), 0);
    push(4, 0, "R8"); push(5, TD, "R8"); push(6, TD, "R8");
    push(4, TD, "R4"); push(5, TD, "R4");
    trig_in = 1'b0;
    drain();
    ctrl = 5'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b0, "R9", "stopped after loop", 32'(busy), 0);
    chk(pat_out == wd(5), "R9", "held after loop", 32'(pat_out), 32'(wd(5)));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule